// File: doc/BRIEF.md
# Dual-Rate Up/Down Counter

This block keeps a count that climbs at the full clock rate and falls at a slower rate set by an integer ratio `K`. Both rates come from one clock. On every enabled cycle the count gains one. An internal divide-by-`K` prescaler counts down and marks every `K`-th enabled cycle with a one-cycle decrement strobe. On those cycles the decrement applies together with that cycle's increment, so the count does not change.

The count stops at its top value by default, and at zero on the way down. A parameter switches the block to modular wrap instead. The enable input freezes the count and the prescaler together, so gaps in the enable stretch the decrement period in step with the increments. `K` and the count width are elaboration-time parameters. With the default ratio of 806, a 12.5 ns clock gives a decrement period of 10.075 us.

The reset is asynchronous and active-low. Its release is expected to arrive already aligned to `clk`.

Top module: `rate_skew_counter`

## Requirements
- R1: While `rst_n` is low, `count` reads 0 and `dec_stb` is low (for `K` > 1). After release, the first strobe appears on the `K`-th enabled cycle.
- R2: On an enabled cycle without a strobe, `count` rises by exactly one at the next rising edge, unless it is already at its top value.
- R3: `dec_stb` is high during exactly one of every `K` enabled cycles. It is high only in a cycle where `en` is high, and it is valid in that same cycle before the edge.
- R4: On an enabled cycle with `dec_stb` high, the increment and the decrement cancel, and `count` is unchanged after the edge.
- R5: In saturating mode (`OVF_MODE` = `OVF_SAT`), `count` stays at 2^`CNT_W`-1 once it reaches that value and never wraps to zero. A decrement taken alone never goes below zero.
- R6: In wrap mode (`OVF_MODE` = `OVF_WRAP`), an increment from 2^`CNT_W`-1 gives 0.
- R7: While `en` is low, `count` and the prescaler both hold. The strobe position therefore advances only on enabled cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock at the increment rate |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| en | input | 1 | Clock enable for the count and the prescaler |
| count | output | CNT_W | Current count value |
| dec_stb | output | 1 | Decrement strobe, one enabled cycle in every K |

## Verification
`dec_stb` depends only on `en` and the prescaler state, so its result is due within the same cycle. The bench samples it one time unit after driving `en` at a falling edge. `count` is registered, so its result is due one rising edge after the enabled cycle. The bench samples it at the following falling edge, after updating its reference model at the rising edge between. Two instances run together: a saturating one with `K` = 5 and 6 bits, and a wrapping one with `K` = 3 and 4 bits. This lets both overflow modes and the strobe spacing be reached within a short run of random and directed `en` patterns, including a mid-run reset.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  // Selects what the count does at its upper and lower limits
  typedef enum logic {
    OVF_SAT  = 1'b0,
    OVF_WRAP = 1'b1
  } ovf_mode_e;

  // Net effect of the increment and decrement requests in one cycle
  typedef enum logic [1:0] {
    NET_HOLD = 2'd0,
    NET_UP   = 2'd1,
    NET_DOWN = 2'd2
  } net_step_e;

  // Width needed to hold values 0 .. ratio-1, at least one bit
  function automatic int unsigned pre_width(input int unsigned ratio);
    return (ratio > 1) ? $clog2(ratio) : 1;
  endfunction

endpackage

// File: rtl/rsc_prescaler.sv
module rsc_prescaler #(
  parameter int unsigned K = 806
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned PRE_W = rsc_pkg::pre_width(K);
  localparam logic [PRE_W-1:0] RELOAD = PRE_W'(K - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic             at_zero;

  assign at_zero = (pre_q == '0);
  assign tick    = en & at_zero;

  // next state: count down, reload on the terminal value
  always_comb begin
    pre_d = pre_q;
    if (at_zero) begin
      pre_d = RELOAD;
    end else begin
      pre_d = pre_q - 1'b1;
    end
  end

  // register, gated by the clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= RELOAD;
    end else if (en) begin
      pre_q <= pre_d;
    end
  end

  // R3: a strobe only ever appears on an enabled cycle
  p_tick_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> en);

  // R3: after a strobe the period restarts at the reload value
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pre_q == RELOAD));

  // R7: the prescaler freezes while disabled
  p_pre_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pre_q));

  // R3: every enabled non-terminal cycle moves one step toward zero
  p_pre_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !at_zero) |=> (pre_q == $past(pre_q) - 1'b1));

endmodule

// File: rtl/rsc_resolve.sv
module rsc_resolve (
  input  logic                 inc_req,
  input  logic                 dec_req,
  output rsc_pkg::net_step_e   step
);
  // increment and decrement in the same cycle cancel each other
  always_comb begin
    unique case ({inc_req, dec_req})
      2'b10:   step = rsc_pkg::NET_UP;
      2'b01:   step = rsc_pkg::NET_DOWN;
      default: step = rsc_pkg::NET_HOLD;
    endcase
  end
endmodule

// File: rtl/rsc_accum.sv
module rsc_accum #(
  parameter int unsigned        CNT_W    = 16,
  parameter rsc_pkg::ovf_mode_e OVF_MODE = rsc_pkg::OVF_SAT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               dec_seen,
  input  rsc_pkg::net_step_e step,
  output logic [CNT_W-1:0]   count
);
  localparam logic [CNT_W-1:0] TOP   = '1;
  localparam logic             WRAPS = (OVF_MODE == rsc_pkg::OVF_WRAP);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // next state with limit handling
  always_comb begin
    cnt_d = cnt_q;
    unique case (step)
      rsc_pkg::NET_UP: begin
        if (cnt_q == TOP) begin
          cnt_d = WRAPS ? '0 : TOP;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      rsc_pkg::NET_DOWN: begin
        if (cnt_q == '0) begin
          cnt_d = WRAPS ? TOP : '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

  // R4: a strobe cycle leaves the count where it was
  p_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dec_seen) |=> $stable(cnt_q));

  // R7: disabled cycles change nothing
  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q));

  // R2: a plain enabled cycle below the top adds one
  p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dec_seen && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1));

  generate
    if (OVF_MODE == rsc_pkg::OVF_WRAP) begin : g_wrap
      // R6: top value rolls over to zero
      p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !dec_seen && cnt_q == TOP) |=> (cnt_q == '0));
    end else begin : g_sat
      // R5: top value is sticky
      p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !dec_seen && cnt_q == TOP) |=> (cnt_q == TOP));
    end
  endgenerate

endmodule

// File: rtl/rate_skew_counter.sv
module rate_skew_counter #(
  parameter int unsigned        CNT_W    = 16,
  parameter int unsigned        K        = 806,
  parameter rsc_pkg::ovf_mode_e OVF_MODE = rsc_pkg::OVF_SAT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] count,
  output logic             dec_stb
);
  logic               tick;
  rsc_pkg::net_step_e step;

  rsc_prescaler #(.K(K)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .tick  (tick)
  );

  rsc_resolve u_res (
    .inc_req (en),
    .dec_req (tick),
    .step    (step)
  );

  rsc_accum #(.CNT_W(CNT_W), .OVF_MODE(OVF_MODE)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .dec_seen (tick),
    .step     (step),
    .count    (count)
  );

  assign dec_stb = tick;

  // R1: strobe stays low while reset is held
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    (!rst_n && K > 1) |-> !dec_stb);

endmodule

// File: tb/rate_skew_counter_tb.sv
module rate_skew_counter_tb;
  localparam time CLK_P = 10ns;
  localparam int  S_K = 5;
  localparam int  S_W = 6;
  localparam int  W_K = 3;
  localparam int  W_W = 4;
  localparam int  S_TOP = (1 << S_W) - 1;
  localparam int  W_TOP = (1 << W_W) - 1;

  logic clk;
  logic rst_n;
  logic en;
  logic [S_W-1:0] s_count;
  logic           s_stb;
  logic [W_W-1:0] w_count;
  logic           w_stb;

  int n_chk;
  int n_fail;
  bit done;

  // reference state
  int ms_cnt, ms_pre, mw_cnt, mw_pre;

  rate_skew_counter #(.CNT_W(S_W), .K(S_K), .OVF_MODE(rsc_pkg::OVF_SAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .count(s_count), .dec_stb(s_stb));

  rate_skew_counter #(.CNT_W(W_W), .K(W_K), .OVF_MODE(rsc_pkg::OVF_WRAP)) u_dut_w (
    .clk(clk), .rst_n(rst_n), .en(en), .count(w_count), .dec_stb(w_stb));

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int next_cnt(input int c, input bit e, input bit stb,
                                  input int top, input bit wrap);
    if (!e || stb) return c;
    if (c == top) return wrap ? 0 : top;
    return c + 1;
  endfunction

  function automatic int next_pre(input int p, input bit e, input int k);
    if (!e) return p;
    return (p == 0) ? k - 1 : p - 1;
  endfunction

  function automatic string cnt_tag(input int c, input bit e, input bit stb,
                                    input int top, input bit wrap);
    if (!e) return "R7";
    if (stb) return "R4";
    if (c == top) return wrap ? "R6" : "R5";
    return "R2";
  endfunction

  // called at a falling edge
  task automatic run_cycle(input bit e);
    bit es, ew;
    string ts, tw;
    en = e;
    #1;
    es = e && (ms_pre == 0);
    ew = e && (mw_pre == 0);
    chk("R3 strobe sat", int'(s_stb), int'(es));
    chk("R3 strobe wrap", int'(w_stb), int'(ew));
    ts = cnt_tag(ms_cnt, e, es, S_TOP, 1'b0);
    tw = cnt_tag(mw_cnt, e, ew, W_TOP, 1'b1);
    @(posedge clk);
    ms_cnt = next_cnt(ms_cnt, e, es, S_TOP, 1'b0);
    mw_cnt = next_cnt(mw_cnt, e, ew, W_TOP, 1'b1);
    ms_pre = next_pre(ms_pre, e, S_K);
    mw_pre = next_pre(mw_pre, e, W_K);
    @(negedge clk);
    chk({ts, " count sat"}, int'(s_count), ms_cnt);
    chk({tw, " count wrap"}, int'(w_count), mw_cnt);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset count sat", int'(s_count), 0);
    chk("R1 reset count wrap", int'(w_count), 0);
    chk("R1 reset strobe sat", int'(s_stb), 0);
    chk("R1 reset strobe wrap", int'(w_stb), 0);
    ms_cnt = 0; mw_cnt = 0;
    ms_pre = S_K - 1; mw_pre = W_K - 1;
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; en = 1'b0;
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();
    // R1: first strobe on the K-th enabled cycle, then period K (R3)
    for (int i = 0; i < 12; i++) run_cycle(1'b1);
    // R7: freeze for several cycles
    for (int i = 0; i < 7; i++) run_cycle(1'b0);
    // R5 and R6: long enabled run to reach both limits
    for (int i = 0; i < 110; i++) run_cycle(1'b1);
    chk("R5 saturated top", int'(s_count), S_TOP);
    // R7 mixed with sparse enable
    for (int i = 0; i < 400; i++) run_cycle(($urandom % 4) != 0);
    // mid-run reset
    run_cycle(1'b1);
    do_reset();
    for (int i = 0; i < 300; i++) run_cycle(($urandom % 3) != 0);
    for (int i = 0; i < 40; i++) run_cycle(($urandom % 2) != 0);
    finish_run();
  end

endmodule